// File: doc/BRIEF.md
# Quadrature Position Decoder with Range Wrap

This block turns two encoder signals into a position count. The two signals can be read as a pair of phases, where each change of one phase moves the count by one step. They can also be read as a count and direction pair, where phase B sets the direction and each rising edge of phase A is one step. Before decoding, each input is synchronised into the clock domain. Each input can then be inverted, and it can be passed through a glitch filter that has its own enable and its own length.

The count stays between a programmable low limit and high limit. A step up from the high limit wraps the count to the low limit. A step down from the low limit wraps it to the high limit. Each wrap sets a sticky overflow flag and records whether the wrap happened at the top or at the bottom of the range. A direction flag follows the last counted step. A clear strobe reloads the count with the low limit.

Top module: `qdec_wrap`

## Requirements
- R1: While rst_ni is low, count_o is 0, dir_up_o is 1, ovf_o is 0 and ovf_top_o is 0.
- R2: With mode_cnt_dir_i = 0, each change of the decoded {A,B} pair along 00→10→11→01→00 adds one to the count, and each change along 00→01→11→10→00 subtracts one.
- R3: With mode_cnt_dir_i = 0, a change in which both decoded phases flip in the same sample leaves count_o, dir_up_o and the overflow flags unchanged.
- R4: With mode_cnt_dir_i = 1, each rising edge of decoded A is one step: up when decoded B = 1 and down when decoded B = 0. A falling edge of A and any change of B do not step.
- R5: inv_a_i = 1 inverts the A pin before decoding, and inv_b_i = 1 inverts the B pin.
- R6: When a phase's filter enable is 1 and its filter value N is nonzero, a level change on that phase is accepted only after it has held for N consecutive clock cycles. A shorter pulse is dropped. When the filter is disabled or N = 0, the phase passes through unfiltered.
- R7: A step up while count_o equals high_lim_i loads low_lim_i, sets ovf_o and sets ovf_top_o to 1.
- R8: A step down while count_o equals low_lim_i loads high_lim_i, sets ovf_o and sets ovf_top_o to 0.
- R9: Every counted step sets dir_up_o: 1 for a step up and 0 for a step down. The flag holds its value between steps.
- R10: ovf_o stays at 1 until a cycle with ovf_clr_i = 1 clears it. If a wrap happens in the same cycle, the set wins.
- R11: A clear_i pulse loads count_o with low_lim_i on the next clock edge, and a step in that same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_a_i | input | 1 | Encoder phase A, or the count input in count/direction mode |
| phase_b_i | input | 1 | Encoder phase B, or the direction input in count/direction mode |
| mode_cnt_dir_i | input | 1 | 0: quadrature phases, 1: count and direction |
| inv_a_i | input | 1 | Invert phase A |
| inv_b_i | input | 1 | Invert phase B |
| flt_en_a_i | input | 1 | Filter enable for phase A |
| flt_en_b_i | input | 1 | Filter enable for phase B |
| flt_val_a_i | input | FLT_W | Filter length for phase A, in cycles |
| flt_val_b_i | input | FLT_W | Filter length for phase B, in cycles |
| low_lim_i | input | CNT_W | Low limit of the count range |
| high_lim_i | input | CNT_W | High limit of the count range |
| clear_i | input | 1 | Load the count with the low limit |
| ovf_clr_i | input | 1 | Write-one-to-clear for the overflow flag |
| count_o | output | CNT_W | Position count |
| dir_up_o | output | 1 | Direction of the last counted step (1 = up) |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_top_o | output | 1 | Last wrap happened at the high limit (1) or at the low limit (0) |

## Verification
Each decoder keeps one sample of the previous phase pair. If that sample is wrong, the next legal edge is read as the wrong direction or as an illegal double change. The error then shows on count_o as an off-by-one, or as a step with the wrong sign, within about four clock cycles of the pin change. A filter run counter that is wrong lets a short glitch through, or drops a long pulse, and count_o shows this by the next settle window. Limit compare errors show at the first wrap: the count lands on the wrong limit, or ovf_top_o has the wrong value. The bench walks through both wrap directions for this reason.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DN   = 2'b10
  } step_e;
endpackage

// File: rtl/qdec_in_cond.sv
module qdec_in_cond #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FLT_W       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             inv_i,
  input  logic             flt_en_i,
  input  logic [FLT_W-1:0] flt_val_i,
  output logic             sig_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   samp;
  logic [FLT_W-1:0]       run_q;
  logic [FLT_W:0]         run_nxt;
  logic                   sig_q;
  logic                   bypass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i ^ inv_i};
  end

  assign samp    = sync_q[SYNC_STAGES-1];
  assign bypass  = !flt_en_i || (flt_val_i == '0);
  assign run_nxt = {1'b0, run_q} + 1'b1;

  // accept a new level only after it has held for flt_val_i consecutive cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q <= 1'b0;
      run_q <= '0;
    end else if (bypass) begin
      sig_q <= samp;
      run_q <= '0;
    end else if (samp == sig_q) begin
      run_q <= '0;
    end else if (run_nxt >= {1'b0, flt_val_i}) begin
      sig_q <= samp;
      run_q <= '0;
    end else begin
      run_q <= run_nxt[FLT_W-1:0];
    end
  end

  assign sig_o = sig_q;

  // R6
  flt_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass |=> sig_o == $past(samp));

  // R6
  flt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass && samp == sig_o) |=> $stable(sig_o));
endmodule

// File: rtl/qdec_step_dec.sv
module qdec_step_dec
  import qdec_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  mode_cnt_dir_i,
  input  logic  a_i,
  input  logic  b_i,
  output step_e step_o
);
  logic prev_a_q, prev_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_a_q <= 1'b0;
      prev_b_q <= 1'b0;
    end else begin
      prev_a_q <= a_i;
      prev_b_q <= b_i;
    end
  end

  always_comb begin
    step_o = STEP_NONE;
    if (mode_cnt_dir_i) begin
      if (a_i && !prev_a_q) step_o = b_i ? STEP_UP : STEP_DN;
    end else begin
      case ({prev_a_q, prev_b_q, a_i, b_i})
        4'b0010, 4'b1011, 4'b1101, 4'b0100: step_o = STEP_UP;
        4'b0001, 4'b0111, 4'b1110, 4'b1000: step_o = STEP_DN;
        default:                            step_o = STEP_NONE;
      endcase
    end
  end

  // R3
  dbl_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_cnt_dir_i && a_i != prev_a_q && b_i != prev_b_q) |-> step_o == STEP_NONE);

  // R4
  a_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_cnt_dir_i && !a_i) |-> step_o == STEP_NONE);
endmodule

// File: rtl/qdec_wrap_cnt.sv
module qdec_wrap_cnt
  import qdec_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  step_e            step_i,
  input  logic             clear_i,
  input  logic             ovf_clr_i,
  input  logic [CNT_W-1:0] low_i,
  input  logic [CNT_W-1:0] high_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_up_o,
  output logic             ovf_o,
  output logic             ovf_top_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             dir_q, ovf_q, top_q;
  logic             at_high, at_low;

  assign at_high = (cnt_q == high_i);
  assign at_low  = (cnt_q == low_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
      ovf_q <= 1'b0;
      top_q <= 1'b0;
    end else begin
      if (ovf_clr_i) ovf_q <= 1'b0;
      if (clear_i) begin
        cnt_q <= low_i;
      end else if (step_i == STEP_UP) begin
        dir_q <= 1'b1;
        if (at_high) begin
          cnt_q <= low_i;
          ovf_q <= 1'b1;
          top_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (step_i == STEP_DN) begin
        dir_q <= 1'b0;
        if (at_low) begin
          cnt_q <= high_i;
          ovf_q <= 1'b1;
          top_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign count_o   = cnt_q;
  assign dir_up_o  = dir_q;
  assign ovf_o     = ovf_q;
  assign ovf_top_o = top_q;

  // R7
  wrap_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && step_i == STEP_UP && at_high) |=> (count_o == $past(low_i) && ovf_o && ovf_top_o));

  // R8
  wrap_bot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && step_i == STEP_DN && at_low) |=> (count_o == $past(high_i) && ovf_o && !ovf_top_o));

  // R11
  clear_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_o == $past(low_i));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && step_i == STEP_NONE) |=> ($stable(count_o) && $stable(dir_up_o)));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
endmodule

// File: rtl/qdec_wrap.sv
module qdec_wrap
  import qdec_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned FLT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             phase_a_i,
  input  logic             phase_b_i,
  input  logic             mode_cnt_dir_i,
  input  logic             inv_a_i,
  input  logic             inv_b_i,
  input  logic             flt_en_a_i,
  input  logic             flt_en_b_i,
  input  logic [FLT_W-1:0] flt_val_a_i,
  input  logic [FLT_W-1:0] flt_val_b_i,
  input  logic [CNT_W-1:0] low_lim_i,
  input  logic [CNT_W-1:0] high_lim_i,
  input  logic             clear_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_up_o,
  output logic             ovf_o,
  output logic             ovf_top_o
);
  localparam int unsigned N_PH = 2;

  logic             pin   [N_PH];
  logic             inv   [N_PH];
  logic             fen   [N_PH];
  logic [FLT_W-1:0] fval  [N_PH];
  logic             sig   [N_PH];
  step_e            step;

  assign pin[0]  = phase_a_i;   assign pin[1]  = phase_b_i;
  assign inv[0]  = inv_a_i;     assign inv[1]  = inv_b_i;
  assign fen[0]  = flt_en_a_i;  assign fen[1]  = flt_en_b_i;
  assign fval[0] = flt_val_a_i; assign fval[1] = flt_val_b_i;

  for (genvar g = 0; g < N_PH; g++) begin : g_ph
    qdec_in_cond #(.SYNC_STAGES(2), .FLT_W(FLT_W)) i_cond (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (pin[g]),
      .inv_i    (inv[g]),
      .flt_en_i (fen[g]),
      .flt_val_i(fval[g]),
      .sig_o    (sig[g])
    );
  end

  qdec_step_dec i_dec (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_cnt_dir_i(mode_cnt_dir_i),
    .a_i           (sig[0]),
    .b_i           (sig[1]),
    .step_o        (step)
  );

  qdec_wrap_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step),
    .clear_i  (clear_i),
    .ovf_clr_i(ovf_clr_i),
    .low_i    (low_lim_i),
    .high_i   (high_lim_i),
    .count_o  (count_o),
    .dir_up_o (dir_up_o),
    .ovf_o    (ovf_o),
    .ovf_top_o(ovf_top_o)
  );
endmodule

// File: tb/test_qdec_wrap.sv
`timescale 1ns/1ps
module test_qdec_wrap;
  localparam int CNT_W = 16;
  localparam int FLT_W = 4;
  localparam int MAX_CYC = 20000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic phase_a_i = 0, phase_b_i = 0, mode_cnt_dir_i = 0;
  logic inv_a_i = 0, inv_b_i = 0, flt_en_a_i = 0, flt_en_b_i = 0;
  logic [FLT_W-1:0] flt_val_a_i = '0, flt_val_b_i = '0;
  logic [CNT_W-1:0] low_lim_i = 16'd5, high_lim_i = 16'd8;
  logic clear_i = 0, ovf_clr_i = 0;
  logic [CNT_W-1:0] count_o;
  logic dir_up_o, ovf_o, ovf_top_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  qdec_wrap #(.CNT_W(CNT_W), .FLT_W(FLT_W)) i_qdec_wrap (.*);

  // {a, b, count[15:0], dir_up, ovf_top}; window limits 5..8
  localparam logic [19:0] AB_VEC [10] = '{
    {1'b1, 1'b0, 16'd6, 1'b1, 1'b0},  // R2 up
    {1'b1, 1'b1, 16'd7, 1'b1, 1'b0},  // R2 up
    {1'b0, 1'b1, 16'd8, 1'b1, 1'b0},  // R2 up
    {1'b0, 1'b0, 16'd5, 1'b1, 1'b1},  // R7 wrap top
    {1'b0, 1'b1, 16'd8, 1'b0, 1'b0},  // R8 wrap bottom
    {1'b1, 1'b1, 16'd7, 1'b0, 1'b0},  // R2 down
    {1'b1, 1'b0, 16'd6, 1'b0, 1'b0},  // R2 down
    {1'b0, 1'b0, 16'd5, 1'b0, 1'b0},  // R9 down
    {1'b1, 1'b1, 16'd5, 1'b0, 1'b0},  // R3 illegal
    {1'b0, 1'b1, 16'd6, 1'b1, 1'b0}   // R2 up again
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    tick(3);
    chk("R1 count", count_o, 0);
    chk("R1 dir", dir_up_o, 1);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 top", ovf_top_o, 0);
    rst_ni = 1'b1;
    tick(8);
    clear_i = 1; tick(1); clear_i = 0; tick(2);
    chk("R11 clear", count_o, 5);

    for (int i = 0; i < 10; i++) begin
      phase_a_i = AB_VEC[i][19];
      phase_b_i = AB_VEC[i][18];
      tick(8);
      chk($sformatf("R2/R3/R7/R8 vec%0d count", i), count_o, AB_VEC[i][17:2]);
      chk($sformatf("R9 vec%0d dir", i), dir_up_o, AB_VEC[i][1]);
      chk($sformatf("R7/R8 vec%0d top", i), ovf_top_o, AB_VEC[i][0]);
    end
    chk("R10 sticky", ovf_o, 1);
    ovf_clr_i = 1; tick(1); ovf_clr_i = 0; tick(2);
    chk("R10 cleared", ovf_o, 0);

    // count/direction mode, pins a=0 b=1, count 6
    mode_cnt_dir_i = 1; tick(8);
    phase_a_i = 1; tick(8); chk("R4 rise up", count_o, 7);
    phase_a_i = 0; tick(8); chk("R4 fall ignored", count_o, 7);
    phase_b_i = 0; tick(8); chk("R4 b change ignored", count_o, 7);
    phase_a_i = 1; tick(8); chk("R4 rise down", count_o, 6);
    chk("R9 dir down", dir_up_o, 0);
    phase_a_i = 0; tick(8);

    inv_b_i = 1; tick(8);
    phase_a_i = 1; tick(8); chk("R5 inv b up", count_o, 7);
    phase_a_i = 0; tick(8);
    inv_a_i = 1; tick(8); chk("R5 inv a rise", count_o, 8);
    phase_a_i = 1; tick(8); chk("R5 inv a fall", count_o, 8);
    phase_a_i = 0; tick(8);
    chk("R7 wrap count", count_o, 5);
    chk("R7 wrap top", ovf_top_o, 1);
    chk("R10 set again", ovf_o, 1);
    inv_a_i = 0; tick(8);
    inv_b_i = 0; tick(8);
    chk("R5 restore no step", count_o, 5);

    flt_en_a_i = 1; flt_val_a_i = 4'd6; tick(4);
    phase_a_i = 1; tick(3); phase_a_i = 0; tick(20);
    chk("R6 glitch dropped", count_o, 5);
    phase_a_i = 1; tick(12); phase_a_i = 0; tick(20);
    chk("R8 wrap via filter", count_o, 8);
    chk("R8 top low", ovf_top_o, 0);
    flt_en_a_i = 0; tick(4);

    low_lim_i = 16'd20; high_lim_i = 16'd30;
    clear_i = 1; tick(1); clear_i = 0; tick(2);
    chk("R11 new low", count_o, 20);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule